// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a 16-tap finite impulse response filter for 8-bit two's complement samples, and it contains no multipliers. Its coefficients are fixed by a module parameter. Every table it uses is computed while the design is elaborated.

On every clock of a filter cycle, one bit from each tap forms the addresses of four small coefficient-sum tables, one table for each group of four taps. The four table outputs are summed in a two-level adder tree. The sum is then folded into a right-shifting accumulator. The lowest bit of the samples is processed first, and on the sign-bit clock the sum is subtracted instead of added. One sample therefore takes eight clocks.

The newest sample sits in a parallel-load shift register. The older samples are held in fifteen 8-entry, 1-bit-wide memories that share one bit counter. Each bit is read from one memory and written at the same address of the next memory, so the whole history moves one tap per filter cycle. The oldest word falls off the end.

Samples enter through a valid/ready handshake. Each result leaves as a 20-bit word, qualified by a one-clock valid pulse.

Top module: `da_fir_serial`

## Requirements
- R1: A synchronous reset drives in_ready high, out_valid low and out_data to zero, and clears the sample history. After reset, the first outputs treat all earlier samples as zero.
- R2: in_ready is high when the filter is idle, and also in the final bit cycle of a running filter cycle. It is low in every other running cycle. A sample is taken when in_valid and in_ready are both high at a rising edge.
- R3: A sample taken at rising edge E produces out_valid high for exactly one clock, after edge E+8. Exactly one result is produced for each sample taken.
- R4: out_data is the 20-bit two's complement value of the sum over k = 0..15 of c[k]·x[n−k]. Here x[n] is the newest sample taken, and c[k] is bits [8k+7:8k] of the COEFS parameter.
- R5: Both samples and coefficients are two's complement, including the extreme values −128 and 127.
- R6: out_data keeps its value in every cycle in which out_valid is low.
- R7: A sample can be taken in the final bit cycle of the previous one, so a continuous stream runs at one sample every 8 clocks.
- R8: in_valid and in_data have no effect while in_ready is low. Values offered then never enter the history.
- R9: The sample history is preserved across idle gaps of any length.
- R10: A single sample of 1 followed by zeros produces the coefficients c[0], c[1], …, c[15] in order. An all-zero history produces 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A new sample is offered |
| in_ready | output | 1 | The filter can take a sample at this edge |
| in_data | input | 8 | Sample, two's complement |
| out_valid | output | 1 | One-clock pulse marking a new result |
| out_data | output | 20 | Filter result, two's complement |

## Verification
The in-design assertions hold on every cycle:
- in_ready drops right after a sample is taken.
- out_valid is a single-clock pulse that ends a filter cycle which started exactly eight clocks earlier.
- out_data does not move between pulses.
- The history storage stays frozen while the filter idles.
- Every final sum fits the 20-bit output.

Only the bench scenarios can show the remaining behaviour:
- the arithmetic is correct, against a convolution model, over all 256 sample values, impulses and extremes;
- history survives idle gaps and is cleared by reset;
- samples offered while in_ready is low are dropped.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_e;

   // tap 15 in the top byte, tap 0 in the bottom byte
   localparam logic [127:0] DA_DEFAULT_COEFS =
      128'h01FE_06F5_16D3_5A80_7F64_C423_EC0C_F903;

endpackage

// File: rtl/da_fir_delay.sv
module da_fir_delay #(
   parameter int N_TAPS = 16,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] in_sample,
   input  logic              shift_en,
   input  logic [CNT_W-1:0]  bit_idx,
   output logic [N_TAPS-1:0] tap_bits
);

   logic [DATA_W-1:0]              head_q;
   logic [N_TAPS-1:1][DATA_W-1:0]  hist_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         head_q <= '0;
         hist_q <= '0;
      end else begin
         if (load)
            head_q <= in_sample;
         else if (shift_en)
            head_q <= head_q >> 1;
         if (shift_en) begin
            hist_q[1][bit_idx] <= head_q[0];
            for (int j = 2; j < N_TAPS; j++)
               hist_q[j][bit_idx] <= hist_q[j-1][bit_idx];
         end
      end
   end

   assign tap_bits[0] = head_q[0];
   for (genvar j = 1; j < N_TAPS; j++) begin : g_tap
      assign tap_bits[j] = hist_q[j][bit_idx];
   end

   AST_HIST_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (!shift_en && !load) |=> ($stable(hist_q) && $stable(head_q)));  // R9

endmodule

// File: rtl/da_fir_lut_bank.sv
module da_fir_lut_bank #(
   parameter int                         N_TAPS = 16,
   parameter int                         GROUP  = 4,
   parameter int                         COEF_W = 8,
   parameter int                         LUT_W  = 10,
   parameter logic [N_TAPS*COEF_W-1:0]   COEFS  = '0
) (
   input  logic [N_TAPS-1:0]                    tap_bits,
   output logic [(N_TAPS/GROUP)*LUT_W-1:0]      lut_out
);

   localparam int N_GROUPS = N_TAPS / GROUP;
   localparam int DEPTH    = 2 ** GROUP;

   function automatic logic signed [LUT_W-1:0] entry_val(input int base, input int addr);
      int s;
      s = 0;
      for (int i = 0; i < GROUP; i++)
         if (((addr >> i) & 1) != 0)
            s += int'($signed(COEFS[(base+i)*COEF_W +: COEF_W]));
      return LUT_W'(s);
   endfunction

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
      logic signed [LUT_W-1:0] tbl [DEPTH];
      for (genvar a = 0; a < DEPTH; a++) begin : g_ent
         localparam logic signed [LUT_W-1:0] ENTRY = entry_val(g*GROUP, a);
         assign tbl[a] = ENTRY;
      end
      assign lut_out[g*LUT_W +: LUT_W] = tbl[tap_bits[g*GROUP +: GROUP]];
   end

endmodule

// File: rtl/da_fir_acc.sv
module da_fir_acc #(
   parameter int N_GROUPS = 4,
   parameter int LUT_W    = 10,
   parameter int DATA_W   = 8,
   parameter int OUT_W    = 20
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        clear,
   input  logic                        step,
   input  logic                        sign_step,
   input  logic [N_GROUPS*LUT_W-1:0]   lut_in,
   output logic [OUT_W-1:0]            result_next
);

   localparam int LVLS  = $clog2(N_GROUPS);
   localparam int SUM_W = LUT_W + LVLS;
   localparam int HI_W  = SUM_W + 1;
   localparam int FULL_W = HI_W + DATA_W;

   if ((1 << LVLS) != N_GROUPS) begin : g_bad_groups
      $error("group count must be a power of two");
   end
   if (OUT_W > FULL_W) begin : g_bad_out
      $error("output wider than accumulator");
   end

   for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
      logic signed [LUT_W+l-1:0] node [N_GROUPS >> l];
      for (genvar k = 0; k < (N_GROUPS >> l); k++) begin : g_node
         if (l == 0) begin : g_leaf
            assign node[k] = lut_in[k*LUT_W +: LUT_W];
         end else begin : g_add
            assign node[k] = (LUT_W+l)'(g_lvl[l-1].node[2*k]) +
                             (LUT_W+l)'(g_lvl[l-1].node[2*k+1]);
         end
      end
   end

   logic signed [SUM_W-1:0] tree_sum;
   logic signed [HI_W-1:0]  hi_q;
   logic [DATA_W-1:0]       lo_q;
   logic signed [HI_W:0]    sum_ext, t;
   logic [FULL_W-1:0]       full_next;

   assign tree_sum  = g_lvl[LVLS].node[0];
   assign sum_ext   = (HI_W+1)'(tree_sum);
   assign t         = (HI_W+1)'(hi_q) + (sign_step ? -sum_ext : sum_ext);
   assign full_next = {t[HI_W:1], t[0], lo_q[DATA_W-1:1]};
   assign result_next = full_next[OUT_W-1:0];

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (step) begin
         hi_q <= t[HI_W:1];
         lo_q <= {t[0], lo_q[DATA_W-1:1]};
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (step && sign_step) |-> ($signed(full_next) == FULL_W'($signed(full_next[OUT_W-1:0]))));  // R4

endmodule

// File: rtl/da_fir_serial.sv
module da_fir_serial
   import da_fir_pkg::*;
#(
   parameter int                        N_TAPS = 16,
   parameter int                        DATA_W = 8,
   parameter int                        COEF_W = 8,
   parameter int                        GROUP  = 4,
   parameter int                        OUT_W  = 20,
   parameter logic [N_TAPS*COEF_W-1:0]  COEFS  = DA_DEFAULT_COEFS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_data
);

   localparam int N_GROUPS = N_TAPS / GROUP;
   localparam int CNT_W    = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam int LUT_W    = COEF_W + $clog2(GROUP);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   if (N_TAPS % GROUP != 0) begin : g_bad_split
      $error("tap count must be a multiple of the group size");
   end
   if (GROUP < 1 || GROUP > 6) begin : g_bad_group
      $error("group size must be 1..6");
   end
   if (DATA_W < 2 || N_TAPS < 2) begin : g_bad_size
      $error("need at least two taps and two data bits");
   end

   phase_e              phase_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                last, accept, running;
   logic [N_TAPS-1:0]   tap_bits;
   logic [N_GROUPS*LUT_W-1:0] lut_out;
   logic [OUT_W-1:0]    acc_next;

   assign running  = (phase_q == PH_RUN);
   assign last     = running && (cnt_q == LAST);
   assign in_ready = !running || last;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= last;
         if (last)
            out_data <= acc_next;
         if (accept) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
         end else if (last) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
         end else if (running) begin
            cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

   da_fir_delay #(.N_TAPS(N_TAPS), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_delay (
      .clk(clk), .rst(rst), .load(accept), .in_sample(in_data),
      .shift_en(running), .bit_idx(cnt_q), .tap_bits(tap_bits));

   da_fir_lut_bank #(.N_TAPS(N_TAPS), .GROUP(GROUP), .COEF_W(COEF_W),
                     .LUT_W(LUT_W), .COEFS(COEFS)) i_luts (
      .tap_bits(tap_bits), .lut_out(lut_out));

   da_fir_acc #(.N_GROUPS(N_GROUPS), .LUT_W(LUT_W), .DATA_W(DATA_W), .OUT_W(OUT_W)) i_acc (
      .clk(clk), .rst(rst), .clear(accept), .step(running), .sign_step(last),
      .lut_in(lut_out), .result_next(acc_next));

   // independent count of edges since the last accepted sample
   localparam int SC_W = $clog2(DATA_W + 1);
   logic [SC_W-1:0] since_q;
   always_ff @(posedge clk) begin
      if (rst)
         since_q <= SC_W'(DATA_W);
      else if (accept)
         since_q <= '0;
      else if (since_q != SC_W'(DATA_W))
         since_q <= since_q + 1'b1;
   end

   AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
      accept |=> !in_ready);  // R2
   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);  // R3
   AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
      last |-> (since_q == SC_W'(DATA_W - 1)));  // R3
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_data));  // R6

endmodule

// File: tb/test_da_fir_serial.sv
`timescale 1ns/1ps
module test_da_fir_serial;
   import da_fir_pkg::*;

   localparam int NT = 16;
   localparam int DW = 8;
   localparam int OW = 20;
   localparam logic [127:0] C = DA_DEFAULT_COEFS;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic in_ready, out_valid;
   logic [OW-1:0] out_data;

   always #2.5 clk = ~clk;

   da_fir_serial i_da_fir_serial (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int hist [NT];
   logic [OW-1:0] exp_q [$];
   int            acc_q [$];
   string         tag_q [$];
   logic [OW-1:0] last_out = '0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   function automatic int coef(input int k);
      return int'($signed(C[k*8 +: 8]));
   endfunction

   task automatic clear_model();
      for (int k = 0; k < NT; k++) hist[k] = 0;
      exp_q.delete(); acc_q.delete(); tag_q.delete();
      last_out = '0;
   endtask

   // drive one sample; noisy offers junk while in_ready is low (R8)
   task automatic send(input logic [DW-1:0] x, input string tag, input bit noisy);
      int s;
      @(negedge clk);
      while (!in_ready) begin
         if (noisy) begin in_valid = 1'b1; in_data = 8'h80 ^ DW'(cyc * 13); end
         @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = x;
      for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = int'($signed(x));
      s = 0;
      for (int k = 0; k < NT; k++) s += hist[k] * coef(k);
      exp_q.push_back(OW'(s));
      acc_q.push_back(cyc + 1);
      tag_q.push_back(tag);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      in_data  = 8'h5A;
   endtask

   // output monitor: R3 timing, R4/R5/R10 values, R6 hold
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && !done) begin
            if (out_valid) begin
               if (exp_q.size() == 0) begin
                  chk(0, "R3 unexpected out_valid", 1, 0);
               end else begin
                  logic [OW-1:0] e;
                  int a;
                  string t;
                  e = exp_q.pop_front(); a = acc_q.pop_front(); t = tag_q.pop_front();
                  chk(out_data == e, t, int'($signed(out_data)), int'($signed(e)));
                  chk(cyc - a == DW, "R3 latency", cyc - a, DW);
               end
               last_out = out_data;
            end else begin
               chk(out_data == last_out, "R6 hold", int'($signed(out_data)), int'($signed(last_out)));
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "watchdog", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
   end

   task automatic wait_drain();
      int guard = 0;
      while (exp_q.size() != 0 && guard < 200) begin @(negedge clk); guard++; end
      repeat (4) @(negedge clk);
   endtask

   initial begin
      clear_model();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
      chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
      chk(out_data == '0, "R1 out_data", int'(out_data), 0);

      // R10 impulse response, back to back (R7)
      send(8'd1, "R10 impulse", 0);
      for (int k = 1; k < NT + 2; k++) send(8'd0, "R10 impulse", 0);
      wait_drain();

      // R2 in_ready pattern over one filter cycle
      send(8'd5, "R4 single", 0);
      for (int k = 0; k < DW + 1; k++) begin
         @(negedge clk);
         chk(in_ready == (k >= DW - 1), "R2 in_ready phase", int'(in_ready), int'(k >= DW - 1));
      end
      wait_drain();

      // R5 extremes
      for (int k = 0; k < NT + 1; k++) send(8'h80, "R5 min run", 0);
      for (int k = 0; k < NT + 1; k++) send(8'h7F, "R5 max run", 0);
      for (int k = 0; k < NT * 2; k++) send((k % 2) ? 8'h80 : 8'h7F, "R5 alternate", 0);
      wait_drain();

      // R4/R7 sweep over every sample value, back to back
      for (int k = 0; k < 256; k++) send(DW'(k * 37 + 11), "R4 R7 sweep", 0);
      wait_drain();

      // R9 idle gaps of varied length
      for (int k = 0; k < 24; k++) begin
         send(DW'(k * 91 + 3), "R9 gapped", 0);
         repeat (k % 7 * 5) @(negedge clk);
      end
      wait_drain();

      // R8 junk offered while not ready
      for (int k = 0; k < 40; k++) send(DW'(k * 29 + 200), "R8 noisy", 1);
      wait_drain();

      // R1 reset in the middle of a filter cycle clears history
      send(8'h7F, "R1 pre-reset", 0);
      repeat (3) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      clear_model();
      rst = 1'b0;
      chk(in_ready == 1'b1, "R1 in_ready mid", int'(in_ready), 1);
      chk(out_valid == 1'b0, "R1 out_valid mid", int'(out_valid), 0);
      chk(out_data == '0, "R1 out_data mid", int'(out_data), 0);
      send(8'd1, "R1 R10 impulse after reset", 0);
      for (int k = 1; k < NT; k++) send(8'd0, "R1 R10 impulse after reset", 0);
      wait_drain();

      // R3 no stray results
      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R3 pending results", exp_q.size(), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
   end

endmodule